// File: doc/BRIEF.md
# Grid PWM Dimming Generator

This block sets the brightness of a multiplexed vacuum fluorescent display. It does this by gating the enable of each grid (digit) time slot. Every grid period is cut into sixteen equal sub-slots, which an external sub-slot tick steps through. The grid enable is asserted from the first sub-slot for a number of sub-slots chosen by a 3-bit dimming code, and is held low for the rest of the period.

The eight steps do not form a linear ramp. In rising order the active widths are 1, 2, 4, 10, 11, 12, 13 and 14 sixteenths, so the step from the third to the fourth code is large. A full 16/16 duty is never produced, which leaves at least two blanking sub-slots in every period.

The dimming code and the display-on flag are sampled only at a period boundary. A boundary is either a start-of-period strobe or the counter's own wrap from the last sub-slot back to zero, so no period is ever cut short or glitched. The block raises an end-of-period flag for one clock on every wrap.

Top module: `grid_dimmer`

## Requirements
- R1: A synchronous reset clears the sub-slot counter, the latched code (to 000) and the latched display-on state. Grid enable and end-of-period are low after reset, and grid enable stays low until the first period boundary.
- R2: The sub-slot counter advances by one on each clock that has slot_tick high and period_start low. On the tick that takes it from 15 to 0, period_end is high in the following clock.
- R3: Dimming codes 0 through 7 select active widths of 1, 2, 4, 10, 11, 12, 13 and 14 sub-slots respectively.
- R4: While the latched display-on state is set, grid_en is high exactly while the sub-slot index is below the selected width, starting at sub-slot 0.
- R5: dim_code and disp_on are latched only at a boundary, meaning a clock with period_start high or a wrapping tick. A change at any other time has no effect on grid_en until the next boundary.
- R6: If disp_on is low at a boundary, grid_en stays low for the whole period that follows, whatever the code.
- R7: period_start resets the counter to 0 and wins over a slot_tick in the same clock.
- R8: period_end is high for one clock per wrap only.
- R9: grid_en is never high in sub-slots 14 and 15.
- R10: With neither slot_tick nor period_start high, the counter and grid_en hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slot_tick | input | 1 | Advance to the next sub-slot |
| period_start | input | 1 | Restart the grid period at sub-slot 0 and latch the settings |
| dim_code | input | 3 | Brightness step, 000 dimmest to 111 brightest |
| disp_on | input | 1 | Display enable, sampled at a boundary |
| grid_en | output | 1 | Grid-active enable for the current sub-slot |
| period_end | output | 1 | One-clock pulse after the counter wraps |

## Verification
The bench builds the block with its default of four counter bits, which gives sixteen sub-slots. With that setting every wrap, every one of the eight widths and both blanking sub-slots can be reached within a few dozen clocks. Directed periods measure the active width for each code and check the boundary-only latching. A long seeded random run mixes irregular ticks, early restarts, display-off periods and occasional resets against a bench model.

// File: rtl/gdim_pkg.sv
package gdim_pkg;
    localparam int CODE_W  = 3;
    localparam int BASE_W  = 4;   // sixteenths resolution of the step table

    // active width of each brightness step in sixteenths of a period
    function automatic logic [BASE_W:0] step_sixteenths(input logic [CODE_W-1:0] code);
        logic [BASE_W:0] w;
        case (code)
            3'd0:    w = 5'd1;
            3'd1:    w = 5'd2;
            3'd2:    w = 5'd4;
            3'd3:    w = 5'd10;
            3'd4:    w = 5'd11;
            3'd5:    w = 5'd12;
            3'd6:    w = 5'd13;
            default: w = 5'd14;
        endcase
        return w;
    endfunction
endpackage

// File: rtl/gdim_slot_counter.sv
module gdim_slot_counter #(
    parameter int SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              start_i,
    output logic [SLOT_W-1:0] cnt_o,
    output logic              end_o,
    output logic              load_o
);
    localparam logic [SLOT_W-1:0] LAST = '1;

    typedef struct packed {
        logic [SLOT_W-1:0] cnt;
        logic              pend;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    wrap;

    always_comb begin
        wrap        = tick_i && !start_i && (st_q.cnt == LAST);
        st_d        = st_q;
        st_d.pend   = wrap;
        if (start_i)
            st_d.cnt = '0;
        else if (tick_i)
            st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign end_o  = st_q.pend;
    assign load_o = start_i | wrap;

    a_r2_wrap_flag: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !start_i && cnt_o == LAST) |=> (cnt_o == '0 && end_o));
    a_r7_restart: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (cnt_o == '0));
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        end_o |=> !end_o);
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !start_i) |=> $stable(cnt_o));
endmodule

// File: rtl/gdim_setting_latch.sv
module gdim_setting_latch
    import gdim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              on_i,
    output logic [CODE_W-1:0] code_o,
    output logic              on_o
);
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              on;
    } set_st_t;

    set_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.code = code_i;
            st_d.on   = on_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign code_o = st_q.code;
    assign on_o   = st_q.on;

    a_r5_code_held: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> ($stable(code_o) && $stable(on_o)));
endmodule

// File: rtl/gdim_gate.sv
module gdim_gate
    import gdim_pkg::*;
#(
    parameter int SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SLOT_W-1:0] cnt_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              on_i,
    output logic              en_o
);
    localparam int WID_W = SLOT_W + 1;
    localparam int SCALE = SLOT_W - BASE_W;

    logic [WID_W-1:0] width;

    always_comb begin
        width = WID_W'(step_sixteenths(code_i)) << SCALE;
        en_o  = on_i && ({1'b0, cnt_i} < width);
    end

    a_r9_blanking: assert property (@(posedge clk) disable iff (rst)
        (cnt_i >= SLOT_W'((1 << SLOT_W) - 2)) |-> !en_o);
endmodule

// File: rtl/grid_dimmer.sv
module grid_dimmer
    import gdim_pkg::*;
#(
    parameter int SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slot_tick,
    input  logic              period_start,
    input  logic [CODE_W-1:0] dim_code,
    input  logic              disp_on,
    output logic              grid_en,
    output logic              period_end
);
    logic [SLOT_W-1:0] cnt;
    logic              load;
    logic [CODE_W-1:0] code_q;
    logic              on_q;

    gdim_slot_counter #(.SLOT_W(SLOT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (slot_tick),
        .start_i (period_start),
        .cnt_o   (cnt),
        .end_o   (period_end),
        .load_o  (load)
    );

    gdim_setting_latch u_set (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .code_i (dim_code),
        .on_i   (disp_on),
        .code_o (code_q),
        .on_o   (on_q)
    );

    gdim_gate #(.SLOT_W(SLOT_W)) u_gate (
        .clk    (clk),
        .rst    (rst),
        .cnt_i  (cnt),
        .code_i (code_q),
        .on_i   (on_q),
        .en_o   (grid_en)
    );

    a_r6_dark_period: assert property (@(posedge clk) disable iff (rst)
        (load && !disp_on) |=> !grid_en);
    a_r4_slot0_lit: assert property (@(posedge clk) disable iff (rst)
        (period_start && disp_on) |=> grid_en);
endmodule

// File: tb/tb_grid_dimmer.sv
module tb_grid_dimmer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       slot_tick = 1'b0;
    logic       period_start = 1'b0;
    logic [2:0] dim_code = 3'd0;
    logic       disp_on = 1'b0;
    logic       grid_en;
    logic       period_end;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    // bench model state
    int         m_cnt = 0;
    logic [2:0] m_code = 3'd0;
    bit         m_on = 1'b0;
    bit         m_pend = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    grid_dimmer dut (
        .clk(clk), .rst(rst), .slot_tick(slot_tick), .period_start(period_start),
        .dim_code(dim_code), .disp_on(disp_on), .grid_en(grid_en), .period_end(period_end)
    );

    function automatic int exp_width(input logic [2:0] c);
        int t[8] = '{1, 2, 4, 10, 11, 12, 13, 14};
        return t[c];
    endfunction

    function automatic bit exp_en();
        return m_on && (m_cnt < exp_width(m_code));
    endfunction

    task automatic check(input bit cond, input string tag, input int act, input int exp);
        vectors++;
        if (!cond) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_update();
        bit wrap;
        if (rst) begin
            m_cnt = 0; m_code = 3'd0; m_on = 1'b0; m_pend = 1'b0;
        end else begin
            wrap = slot_tick && !period_start && (m_cnt == 15);
            m_pend = wrap;
            if (period_start || wrap) begin
                m_code = dim_code;
                m_on   = disp_on;
            end
            if (period_start)   m_cnt = 0;
            else if (slot_tick) m_cnt = (m_cnt + 1) % 16;
        end
    endtask

    task automatic step(input bit r, input bit t, input bit s, input logic [2:0] c,
                        input bit on, input string tag);
        rst = r; slot_tick = t; period_start = s; dim_code = c; disp_on = on;
        @(posedge clk);
        model_update();
        @(negedge clk);
        check(grid_en == exp_en(), {tag, " grid_en"}, grid_en, exp_en());
        check(period_end == m_pend, {tag, " period_end"}, period_end, m_pend);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int hi;
        void'($urandom(32'd2718));
        @(negedge clk);
        // R1: reset state and no light before the first boundary
        step(1, 0, 0, 3'd7, 1, "R1");
        step(1, 0, 0, 3'd7, 1, "R1");
        check(grid_en == 1'b0 && period_end == 1'b0, "R1 reset outputs", grid_en, 0);
        for (int k = 0; k < 5; k++) begin
            step(0, 1, 0, 3'd7, 1, "R1");
            check(grid_en == 1'b0, "R1 dark before boundary", grid_en, 0);
        end

        // R3/R4/R2/R8/R9: one full period per code
        for (int c = 0; c < 8; c++) begin
            step(0, 0, 1, 3'(c), 1, "R7");
            hi = grid_en;
            for (int k = 1; k < 16; k++) begin
                step(0, 1, 0, 3'(c), 1, "R4");
                hi += grid_en;
                if (k >= 14) check(grid_en == 1'b0, "R9 blank slot", grid_en, 0);
                step(0, 0, 0, 3'(c), 1, "R10");
            end
            check(hi == exp_width(3'(c)), "R3 active width", hi, exp_width(3'(c)));
            check(16 - hi >= 2, "R9 blanking count", 16 - hi, 2);
            step(0, 1, 0, 3'(c), 1, "R2");
            check(period_end == 1'b1, "R2 wrap flag", period_end, 1);
            step(0, 0, 0, 3'(c), 1, "R8");
            check(period_end == 1'b0, "R8 single pulse", period_end, 0);
        end

        // R5: mid-period code change ignored until boundary
        step(0, 0, 1, 3'd7, 1, "R5");
        for (int k = 1; k < 8; k++) step(0, 1, 0, 3'd0, 0, "R5");
        check(grid_en == 1'b1, "R5 width held", grid_en, 1);
        for (int k = 8; k < 16; k++) step(0, 1, 0, 3'd0, 1, "R5");
        step(0, 1, 0, 3'd0, 1, "R5");   // wrap: code 0 latched
        step(0, 1, 0, 3'd0, 1, "R5");   // slot 1
        check(grid_en == 1'b0, "R5 new code after wrap", grid_en, 0);

        // R6: display off at boundary
        step(0, 0, 1, 3'd7, 0, "R6");
        check(grid_en == 1'b0, "R6 dark slot0", grid_en, 0);
        for (int k = 1; k < 16; k++) step(0, 1, 0, 3'd7, 1, "R6");

        // R7: restart wins over tick
        step(0, 0, 1, 3'd2, 1, "R7");
        for (int k = 0; k < 6; k++) step(0, 1, 0, 3'd2, 1, "R7");
        step(0, 1, 1, 3'd2, 1, "R7");
        check(grid_en == 1'b1, "R7 restart to slot0", grid_en, 1);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            step(($urandom % 200) == 0, ($urandom % 2) == 1, ($urandom % 40) == 0,
                 3'($urandom % 8), ($urandom % 5) != 0, "R4 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule